// File: doc/BRIEF.md
# Eight-Channel Successive-Approximation Converter Control Core

This block is the digital half of an eight-input successive-approximation converter. An external analog multiplexer, a DAC and a comparator sit around it. The core keeps a three-bit channel address, which tells the multiplexer which input to route. It sends an 8-bit trial code to the DAC and reads back a single comparator bit that says whether the selected input is at or above that trial level. It resolves one result bit per conversion clock, most significant bit first, and keeps the finished code in an output latch. That latch drives a bus which can be released to high impedance.

The `startIn` pin acts on both of its edges. Its rising edge wipes the search register, the output latch and the end-of-conversion flag. Its falling edge launches a conversion. `startIn` is brought into the clock domain through a synchronizer, and each edge is found by comparing the synchronized level with a delayed copy. A host sets the address with the latch enable, pulses start, waits for `eoc`, and then raises `outEn` to read the code.

Top module: `sar_mux_core`

## Requirements
- R1: While `addrLatchEn` is high at a rising clock edge, `chanSel` takes `chanAddr`. The value is plain binary, with bit 2 as the most significant, and selects input 0 to 7. While `addrLatchEn` is low, `chanSel` holds its value whatever `chanAddr` does.
- R2: A rising edge on `startIn` clears the search register, the output latch and `eoc`. With `outEn` high, the bus then reads 8'h00 and `eoc` reads 0.
- R3: A falling edge on `startIn` begins a conversion, and `eoc` stays low for as long as the conversion runs.
- R4: Count rising clock edges after `startIn` falls, sampling between edges. `eoc` is still 0 after the 11th edge and is 1 after the 12th edge. This is 2 synchronizer edges, 1 launch edge, 8 bit decisions and 1 load edge.
- R5: Bits are decided MSB first, one per clock. While bit k is under trial, `trialCode` equals the bits already decided, with bit k set and all lower bits zero. Bit k keeps its 1 only if `cmpIn` is high. The first trial code of any conversion is 8'h80. With a comparator that reports input >= trial, the result equals the input code, including 8'h00 and 8'hFF.
- R6: When `outEn` is 1, `dataOe` is 8'hFF and `dataBus` carries the latched result. When `outEn` is 0, `dataOe` is 8'h00 and every bit of `dataBus` is high impedance.
- R7: The output latch loads on the same edge that raises `eoc`, and not before. After that it holds its value through any toggling of `outEn` or change of the channel input, until the next rising edge of `startIn` or the next completed conversion.
- R8: A rising edge of `startIn` during a conversion aborts it. No completion follows, `eoc` stays 0 and the latch reads 8'h00, until `startIn` falls again and a full new conversion finishes.
- R9: After reset, `eoc` is 0, `chanSel` is 0, `trialCode` is 8'h00, `dataOe` is 8'h00, and the bus is high impedance while `outEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| convClk | input | 1 | Conversion clock, supplied from outside |
| rstN | input | 1 | Asynchronous active-low reset |
| addrLatchEn | input | 1 | Level enable for the channel address latch |
| chanAddr | input | 3 | Channel address, binary |
| startIn | input | 1 | Start pin: rising edge clears, falling edge launches |
| outEn | input | 1 | Output enable for the result bus |
| cmpIn | input | 1 | Comparator bit, 1 when the input is at or above the trial level |
| eoc | output | 1 | High once a result is complete |
| chanSel | output | 3 | Latched channel select for the analog multiplexer |
| trialCode | output | 8 | Trial code sent to the DAC |
| dataBus | output | 8 | Three-state result bus |
| dataOe | output | 8 | Drive enable for each bit of the result bus |

## Verification
The embedded assertions watch properties that must hold on every cycle. `chanSel` holds while the latch enable is low. The search index steps down by one each cycle of a conversion. `eoc` stays low during a conversion and rises only out of the load phase. The result latch changes only on a load or a clear. A start rise always returns the control to idle. The bench scenarios show what needs real values and edge counts. They check that the binary search lands on each chosen channel code, including the extremes 8'h00 and 8'hFF, and that the trial code follows the expected sequence. They check the exact 12-edge latency, the high-impedance bus, and the latch holding through toggles of `outEn`. Finally they check that an aborted conversion never completes and that a later conversion still produces the correct code.

// File: rtl/sar_core_pkg.sv
package sar_core_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_LOAD = 2'd2
  } convPhase_t;

  typedef struct packed {
    logic clearAll;
    logic beginConv;
    logic stepBit;
    logic finish;
  } sarStrobe_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_core_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  output sarStrobe_t       strobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic             active,
  output logic             eoc
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   startSync;
  logic                   startDly;
  logic                   startRise;
  logic                   startFall;
  convPhase_t             phase;

  // Synchronizer: one flop per stage.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= startIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  assign startSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startDly <= 1'b0;
    else       startDly <= startSync;
  end

  assign startRise = startSync & ~startDly;
  assign startFall = ~startSync & startDly;

  // Strobe decode. A clear outranks everything else.
  always_comb begin
    strobe = '0;
    if (startRise)            strobe.clearAll  = 1'b1;
    else if (startFall)       strobe.beginConv = 1'b1;
    else if (phase == PH_CONV) strobe.stepBit  = 1'b1;
    else if (phase == PH_LOAD) strobe.finish   = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitIdx <= '0;
      eoc    <= 1'b0;
    end else if (strobe.clearAll) begin
      phase  <= PH_IDLE;
      bitIdx <= '0;
      eoc    <= 1'b0;
    end else if (strobe.beginConv) begin
      phase  <= PH_CONV;
      bitIdx <= TOP_IDX;
      eoc    <= 1'b0;
    end else if (strobe.stepBit) begin
      if (bitIdx == '0) phase  <= PH_LOAD;
      else              bitIdx <= bitIdx - IDX_W'(1);
    end else if (strobe.finish) begin
      phase <= PH_IDLE;
      eoc   <= 1'b1;
    end
  end

  assign active = (phase == PH_CONV);

  // R3
  conv_eoc_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CONV) |-> !eoc)
    else $error("eoc high during conversion");

  // R5
  bit_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CONV && !startRise && !startFall && bitIdx != '0)
      |=> (phase == PH_CONV && bitIdx == $past(bitIdx) - IDX_W'(1)))
    else $error("bit index did not step down");

  // R4
  eoc_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eoc) |-> $past(phase) == PH_LOAD)
    else $error("eoc rose outside load phase");

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    startRise |=> (phase == PH_IDLE && !eoc))
    else $error("start rise did not return to idle");

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_core_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobe_t        strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              active,
  input  logic              cmpIn,
  input  logic              ale,
  input  logic [ADDR_W-1:0] chanAddr,
  output logic [ADDR_W-1:0] chanSel,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] resultQ
);

  logic [DATA_W-1:0] sarQ;
  logic [DATA_W-1:0] bitMask;

  // Address latch: level-enabled, sampled on the clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    chanSel <= '0;
    else if (ale) chanSel <= chanAddr;
  end

  // One search bit per slice.
  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign bitMask[b] = active && (bitIdx == IDX_W'(b));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                  sarQ[b] <= 1'b0;
        else if (strobe.clearAll || strobe.beginConv) sarQ[b] <= 1'b0;
        else if (strobe.stepBit && bitMask[b])      sarQ[b] <= cmpIn;
      end
    end
  endgenerate

  assign trialCode = sarQ | bitMask;

  // Output latch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                resultQ <= '0;
    else if (strobe.clearAll) resultQ <= '0;
    else if (strobe.finish)   resultQ <= sarQ;
  end

  // R1
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ale |=> $stable(chanSel))
    else $error("channel select moved with latch closed");

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.finish || strobe.clearAll) |=> $stable(resultQ))
    else $error("result latch changed without load or clear");

  // R3
  sar_start_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beginConv |=> (sarQ == '0))
    else $error("search register not cleared at launch");

  // R2
  clear_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (resultQ == '0))
    else $error("result latch not cleared");

endmodule

// File: rtl/sar_mux_core.sv
module sar_mux_core
  import sar_core_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              convClk,
  input  logic              rstN,
  input  logic              addrLatchEn,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic              startIn,
  input  logic              outEn,
  input  logic              cmpIn,
  output logic              eoc,
  output logic [ADDR_W-1:0] chanSel,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] dataBus,
  output logic [DATA_W-1:0] dataOe
);

  sarStrobe_t        strobe;
  logic [IDX_W-1:0]  bitIdx;
  logic              active;
  logic [DATA_W-1:0] resultQ;

  sar_ctrl #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk     (convClk),
    .rstN    (rstN),
    .startIn (startIn),
    .strobe  (strobe),
    .bitIdx  (bitIdx),
    .active  (active),
    .eoc     (eoc)
  );

  sar_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk       (convClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bitIdx    (bitIdx),
    .active    (active),
    .cmpIn     (cmpIn),
    .ale       (addrLatchEn),
    .chanAddr  (chanAddr),
    .chanSel   (chanSel),
    .trialCode (trialCode),
    .resultQ   (resultQ)
  );

  assign dataOe  = {DATA_W{outEn}};
  assign dataBus = outEn ? resultQ : {DATA_W{1'bz}};

endmodule

// File: tb/sim_sar_mux_core.sv
`timescale 1ns/1ps
module sim_sar_mux_core;

  localparam int CLK_PERIOD = 2000;

  logic       convClk = 1'b0;
  logic       rstN, addrLatchEn, startIn, outEn, cmpIn;
  logic [2:0] chanAddr;
  logic       eoc;
  logic [2:0] chanSel;
  logic [7:0] trialCode, dataOe;
  wire  [7:0] dataBus;
  logic [7:0] chanVal [8];
  int         checks = 0;
  int         failures = 0;

  always #(CLK_PERIOD/2) convClk = ~convClk;

  // Comparator model: input at or above trial level.
  assign cmpIn = (chanVal[chanSel] >= trialCode);

  sar_mux_core u0 (
    .convClk(convClk), .rstN(rstN), .addrLatchEn(addrLatchEn),
    .chanAddr(chanAddr), .startIn(startIn), .outEn(outEn), .cmpIn(cmpIn),
    .eoc(eoc), .chanSel(chanSel), .trialCode(trialCode),
    .dataBus(dataBus), .dataOe(dataOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setChan(input logic [2:0] ch);
    @(negedge convClk);
    addrLatchEn = 1'b1;
    chanAddr    = ch;
    @(negedge convClk);
    addrLatchEn = 1'b0;
  endtask

  // Start pulse then full conversion, with per-edge checks.
  task automatic runConv(input logic [7:0] expVal, input string req);
    @(negedge convClk);
    outEn   = 1'b1;
    startIn = 1'b1;
    repeat (4) @(negedge convClk);
    startIn = 1'b0;
    for (int n = 1; n <= 12; n++) begin
      @(negedge convClk);
      if (n == 3)  check("R5 first trial", trialCode, 8'h80);
      if (n == 6)  check("R3 eoc low mid", {7'd0, eoc}, 8'h00);
      if (n == 11) begin
        check("R4 eoc low at 11", {7'd0, eoc}, 8'h00);
        check("R7 no early load", dataBus, 8'h00);
      end
    end
    check("R4 eoc high at 12", {7'd0, eoc}, 8'h01);
    check(req, dataBus, expVal);
  endtask

  task automatic testReset();
    check("R9 eoc", {7'd0, eoc}, 8'h00);
    check("R9 chanSel", {5'd0, chanSel}, 8'h00);
    check("R9 trialCode", trialCode, 8'h00);
    check("R9 dataOe", dataOe, 8'h00);
    check("R9 bus z", dataBus, 8'hzz);
  endtask

  task automatic testTrialWalk();
    setChan(3'd3);
    @(negedge convClk);
    outEn = 1'b1; startIn = 1'b1;
    repeat (4) @(negedge convClk);
    startIn = 1'b0;
    for (int n = 1; n <= 12; n++) begin
      @(negedge convClk);
      if (n == 3) check("R5 trial bit7", trialCode, 8'h80);
      if (n == 4) check("R5 trial bit6", trialCode, 8'hC0);
      if (n == 5) check("R5 trial bit5", trialCode, 8'hA0);
    end
    check("R5 walk result", dataBus, 8'hA5);
    check("R1 channel 3 select", {5'd0, chanSel}, 8'h03);
  endtask

  task automatic testCorners();
    setChan(3'd0); runConv(8'h00, "R5 zero code");
    setChan(3'd7); runConv(8'hFF, "R5 full code");
    setChan(3'd1); runConv(8'h01, "R5 lsb only");
    setChan(3'd4); runConv(8'h80, "R5 msb only");
    setChan(3'd6); runConv(8'h7F, "R5 below half");
  endtask

  task automatic testAddrHold();
    setChan(3'd2);
    @(negedge convClk);
    chanAddr = 3'd5;
    repeat (3) @(negedge convClk);
    check("R1 hold with latch closed", {5'd0, chanSel}, 8'h02);
    runConv(8'h3C, "R1 held channel converts");
  endtask

  task automatic testOutEn();
    setChan(3'd5);
    runConv(8'h5A, "R5 channel 5");
    for (int i = 0; i < 3; i++) begin
      @(negedge convClk); outEn = 1'b0;
      @(negedge convClk);
      check("R6 bus z", dataBus, 8'hzz);
      check("R6 oe off", dataOe, 8'h00);
      outEn = 1'b1;
      @(negedge convClk);
      check("R6 oe on", dataOe, 8'hFF);
      check("R7 held result", dataBus, 8'h5A);
    end
    chanVal[5] = 8'h11;
    repeat (5) @(negedge convClk);
    check("R7 ignores input change", dataBus, 8'h5A);
    chanVal[5] = 8'h5A;
  endtask

  task automatic testClear();
    setChan(3'd3);
    runConv(8'hA5, "R5 before clear");
    @(negedge convClk);
    startIn = 1'b1;
    repeat (4) @(negedge convClk);
    check("R2 eoc cleared", {7'd0, eoc}, 8'h00);
    check("R2 result cleared", dataBus, 8'h00);
    startIn = 1'b0;
    repeat (12) @(negedge convClk);
    check("R2 converts after clear", dataBus, 8'hA5);
  endtask

  task automatic testAbort();
    int eocSeen;
    setChan(3'd7);
    @(negedge convClk);
    outEn = 1'b1; startIn = 1'b1;
    repeat (4) @(negedge convClk);
    startIn = 1'b0;
    repeat (6) @(negedge convClk);
    startIn = 1'b1;
    eocSeen = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge convClk);
      if (eoc) eocSeen++;
    end
    check("R8 no completion after abort", eocSeen[7:0], 8'h00);
    check("R8 result cleared", dataBus, 8'h00);
    startIn = 1'b0;
    repeat (11) @(negedge convClk);
    check("R8 eoc low before restart done", {7'd0, eoc}, 8'h00);
    @(negedge convClk);
    check("R8 eoc after restart", {7'd0, eoc}, 8'h01);
    check("R8 restart result", dataBus, 8'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    chanVal[0] = 8'h00; chanVal[1] = 8'h01; chanVal[2] = 8'h3C; chanVal[3] = 8'hA5;
    chanVal[4] = 8'h80; chanVal[5] = 8'h5A; chanVal[6] = 8'h7F; chanVal[7] = 8'hFF;
    rstN = 1'b0; addrLatchEn = 1'b0; chanAddr = 3'd0; startIn = 1'b0; outEn = 1'b0;
    repeat (3) @(negedge convClk);
    testReset();
    rstN = 1'b1;
    @(negedge convClk);
    testTrialWalk();
    testCorners();
    testAddrHold();
    testOutEn();
    testClear();
    testAbort();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule